// File: doc/BRIEF.md
# I3C Transaction Router

This block is the byte-level fabric between a single controller-side transaction port and a parameterized set of target ports. Each START or repeated START rebuilds a participant mask from the targets that claim the presented address. Writes then fan out to every participant, while reads are served by one participant. The router also keeps track of whether the current transfer is a broadcast, whether a common command code (CCC) is in progress, and whether dynamic address assignment (ENTDAA) is running.

Target replies are folded into a single ACK/NACK result for the controller. A NACK from a target is hidden during broadcast CCCs. ENTDAA stays open across repeated STARTs. A STOP issued while ENTDAA is running is signalled to every target, not only to the current participants.

Every controller operation is a one-cycle pulse. Target ports are sampled in the same cycle as the operation. Strobes to the targets are combinational in that cycle. The controller result appears one cycle later.

Top module: `txr_router`

## Requirements
- R1: After reset the participant mask is empty, `bus_busy`, `bcast_active`, `ccc_active` and `daa_active` are low, and `rsp_valid` is low.
- R2: A START replaces the participant mask with the targets whose `tgt_match` bit is set. It pulses `tgt_start_evt` on exactly those targets. One cycle later `rsp_valid` is high, and `bus_busy` is high exactly when the new mask is non-empty.
- R3: A START that no target matches returns `rsp_ack` = 0.
- R4: On a START to a non-broadcast address, the result is NACK if any newly matched target raises `tgt_evt_fail`. On a START to the broadcast address (default 7'h7E), `tgt_evt_fail` is ignored and the START is ACKed whenever at least one target matches.
- R5: A START to the broadcast address sets `bcast_active`, and also clears `ccc_active` unless ENTDAA is running. A START to any other address clears `bcast_active` and leaves `ccc_active` unchanged.
- R6: The first byte written while `bcast_active` is high and `ccc_active` is low is captured as the CCC code, and `ccc_active` is set. If that byte equals the ENTDAA code (default 8'h07), `daa_active` is set.
- R7: `daa_active` stays high across repeated STARTs. While it is high, a START to a non-broadcast address matches no target and is NACKed.
- R8: A write pulses `tgt_wr_en` on every participant. Outside a CCC, any participant's `tgt_wr_nack` makes the result NACK. Inside a CCC, a target NACK reaches the controller only when the code is direct (bit 7 of the code set); for a broadcast code (bit 7 clear) the write is always ACKed.
- R9: A read returns the byte of the lowest-index participant and pulses `tgt_rd_en` on that participant only. With an empty mask the read returns 8'hFF and no target is strobed. Reads always return `rsp_ack` = 1.
- R10: A STOP pulses `tgt_stop_evt` on all targets while ENTDAA is running, and only on the participants otherwise. It empties the mask and clears `bcast_active`, `ccc_active` and `daa_active`. It gives no `rsp_valid`.
- R11: A controller NACK pulses `tgt_nack_evt` on the current participants only. It leaves the mask unchanged and gives no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | START / repeated START pulse |
| ctl_addr | input | ADDR_W | Address presented with START |
| ctl_rnw | input | 1 | Direction of the START (1 = read) |
| ctl_wr | input | 1 | Write byte pulse |
| ctl_wdata | input | 8 | Byte to write |
| ctl_rd | input | 1 | Read byte pulse |
| ctl_nack | input | 1 | Controller NACK pulse |
| ctl_stop | input | 1 | STOP pulse |
| rsp_valid | output | 1 | Result of START, write or read is valid |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rsp_rdata | output | 8 | Read byte |
| bus_busy | output | 1 | Participant mask non-empty |
| bcast_active | output | 1 | Current transfer addressed the broadcast address |
| ccc_active | output | 1 | A CCC is in progress |
| daa_active | output | 1 | ENTDAA is in progress |
| tgt_addr | output | ADDR_W | Address shown to targets for matching |
| tgt_rnw | output | 1 | Direction shown to targets |
| tgt_wdata | output | 8 | Write byte shown to targets |
| tgt_ccc_mode | output | 1 | Current write belongs to a CCC |
| tgt_ccc_code | output | 8 | CCC code in effect for the current write |
| tgt_start_evt | output | N_TGT | START event per target |
| tgt_wr_en | output | N_TGT | Write strobe per target |
| tgt_rd_en | output | N_TGT | Read strobe per target |
| tgt_stop_evt | output | N_TGT | STOP event per target |
| tgt_nack_evt | output | N_TGT | NACK event per target |
| tgt_match | input | N_TGT | Target claims the presented address |
| tgt_evt_fail | input | N_TGT | Target rejects the START event |
| tgt_wr_nack | input | N_TGT | Target NACKs the write |
| tgt_rdata | input | 8*N_TGT | Read byte per target |

## Verification
The assertions assume that at most one controller pulse is high in any cycle, and that target inputs are valid in the same cycle as the pulse they answer. The router does resolve overlapping pulses by a fixed priority (STOP, START, write, read, NACK), but the checks are written only for the one-pulse case. The bench issues one operation per call with all other pulses low. It draws the target match, fail, NACK and data vectors at random, together with the operation itself, and it biases addresses and write bytes toward the broadcast address, the ENTDAA code and direct codes so that every flag transition occurs.

// File: rtl/txr_pkg.sv
package txr_pkg;

  // Direct CCCs carry bit 7 set; broadcast CCCs have it clear.
  function automatic logic ccc_is_direct(input logic [7:0] code);
    return code[7];
  endfunction

  // Fixed priority: lowest set index wins. Returns 0 for an empty mask.
  function automatic int unsigned lowest_idx(input logic [31:0] m);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

  // Fold write NACKs into one controller result.
  function automatic logic write_ack(input logic nack_any, input logic in_ccc,
                                     input logic [7:0] code);
    return !(nack_any && (!in_ccc || ccc_is_direct(code)));
  endfunction

endpackage

// File: rtl/txr_part_track.sv
module txr_part_track #(
  parameter int N_TGT  = 4,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_start,
  input  logic              do_stop,
  input  logic [ADDR_W-1:0] addr,
  input  logic              daa_q,
  input  logic [N_TGT-1:0]  match,
  input  logic [N_TGT-1:0]  evt_fail,
  output logic [N_TGT-1:0]  part_q,
  output logic [N_TGT-1:0]  new_part,
  output logic              start_bcast,
  output logic              start_ack
);

  assign start_bcast = (addr == BCAST_ADDR);
  // During ENTDAA only broadcast STARTs may gather participants.
  assign new_part  = (daa_q && !start_bcast) ? '0 : match;
  assign start_ack = (|new_part) && (start_bcast || !(|(evt_fail & new_part)));

  always_ff @(posedge clk) begin
    if (!rst_n)        part_q <= '0;
    else if (do_stop)  part_q <= '0;
    else if (do_start) part_q <= new_part;
  end

  assert_stop_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop |=> part_q == '0);
  assert_daa_blocks_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_start && daa_q && addr != BCAST_ADDR) |=> part_q == '0);

endmodule

// File: rtl/txr_ccc_state.sv
module txr_ccc_state #(
  parameter logic [7:0] DAA_CODE = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       do_start,
  input  logic       do_stop,
  input  logic       do_wr,
  input  logic       start_bcast,
  input  logic [7:0] wdata,
  output logic       bcast_q,
  output logic       ccc_q,
  output logic       daa_q,
  output logic       wr_in_ccc,
  output logic [7:0] wr_code
);

  logic [7:0] code_q;
  logic       capture;

  assign capture   = do_wr && bcast_q && !ccc_q;
  assign wr_in_ccc = ccc_q || bcast_q;
  assign wr_code   = ccc_q ? code_q : wdata;

  always_ff @(posedge clk) begin
    if (!rst_n || do_stop) begin
      bcast_q <= 1'b0;
      ccc_q   <= 1'b0;
      daa_q   <= 1'b0;
      code_q  <= '0;
    end else if (do_start) begin
      bcast_q <= start_bcast;
      if (start_bcast && !daa_q) ccc_q <= 1'b0;
    end else if (capture) begin
      code_q <= wdata;
      ccc_q  <= 1'b1;
      if (wdata == DAA_CODE) daa_q <= 1'b1;
    end
  end

  assert_daa_survives_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (daa_q && do_start && !do_stop) |=> daa_q);
  assert_stop_clears_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop |=> !bcast_q && !ccc_q && !daa_q);
  assert_capture_opens_ccc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && !do_stop && !do_start && bcast_q && !ccc_q) |=> ccc_q);

endmodule

// File: rtl/txr_resp.sv
module txr_resp #(
  parameter int N_TGT = 4,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               do_start,
  input  logic               do_wr,
  input  logic               do_rd,
  input  logic               start_ack,
  input  logic [N_TGT-1:0]   part_q,
  input  logic [N_TGT-1:0]   wr_nack,
  input  logic               wr_in_ccc,
  input  logic [7:0]         wr_code,
  input  logic [8*N_TGT-1:0] rdata,
  output logic [N_TGT-1:0]   rd_sel,
  output logic               rsp_valid,
  output logic               rsp_ack,
  output logic [7:0]         rsp_rdata
);
  import txr_pkg::*;

  logic [IDX_W-1:0] sel;
  logic             nack_any;

  assign sel      = IDX_W'(lowest_idx(32'(part_q)));
  assign nack_any = |(wr_nack & part_q);

  generate
    for (genvar g = 0; g < N_TGT; g++) begin : g_sel
      assign rd_sel[g] = (|part_q) && (sel == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_rdata <= 8'hFF;
    end else begin
      rsp_valid <= do_start || do_wr || do_rd;
      if (do_start) rsp_ack <= start_ack;
      else if (do_wr) rsp_ack <= write_ack(nack_any, wr_in_ccc, wr_code);
      else if (do_rd) begin
        rsp_ack   <= 1'b1;
        rsp_rdata <= (|part_q) ? rdata[sel*8 +: 8] : 8'hFF;
      end
    end
  end

  assert_empty_read_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && part_q == '0) |=> rsp_valid && rsp_ack && rsp_rdata == 8'hFF);
  assert_bcast_ccc_nack_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && wr_in_ccc && !wr_code[7]) |=> rsp_ack);
  assert_read_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel));

endmodule

// File: rtl/txr_router.sv
module txr_router #(
  parameter int N_TGT  = 4,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E,
  parameter logic [7:0] DAA_CODE = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_start,
  input  logic [ADDR_W-1:0]  ctl_addr,
  input  logic               ctl_rnw,
  input  logic               ctl_wr,
  input  logic [7:0]         ctl_wdata,
  input  logic               ctl_rd,
  input  logic               ctl_nack,
  input  logic               ctl_stop,
  output logic               rsp_valid,
  output logic               rsp_ack,
  output logic [7:0]         rsp_rdata,
  output logic               bus_busy,
  output logic               bcast_active,
  output logic               ccc_active,
  output logic               daa_active,
  output logic [ADDR_W-1:0]  tgt_addr,
  output logic               tgt_rnw,
  output logic [7:0]         tgt_wdata,
  output logic               tgt_ccc_mode,
  output logic [7:0]         tgt_ccc_code,
  output logic [N_TGT-1:0]   tgt_start_evt,
  output logic [N_TGT-1:0]   tgt_wr_en,
  output logic [N_TGT-1:0]   tgt_rd_en,
  output logic [N_TGT-1:0]   tgt_stop_evt,
  output logic [N_TGT-1:0]   tgt_nack_evt,
  input  logic [N_TGT-1:0]   tgt_match,
  input  logic [N_TGT-1:0]   tgt_evt_fail,
  input  logic [N_TGT-1:0]   tgt_wr_nack,
  input  logic [8*N_TGT-1:0] tgt_rdata
);

  // Operation decode, fixed priority STOP > START > write > read > NACK.
  logic do_stop, do_start, do_wr, do_rd, do_nack;
  assign do_stop  = ctl_stop;
  assign do_start = ctl_start && !do_stop;
  assign do_wr    = ctl_wr && !do_stop && !ctl_start;
  assign do_rd    = ctl_rd && !do_stop && !ctl_start && !ctl_wr;
  assign do_nack  = ctl_nack && !do_stop && !ctl_start && !ctl_wr && !ctl_rd;

  logic [N_TGT-1:0] part_q, new_part, rd_sel;
  logic             start_bcast, start_ack, wr_in_ccc;
  logic [7:0]       wr_code;

  txr_part_track #(.N_TGT(N_TGT), .ADDR_W(ADDR_W), .BCAST_ADDR(BCAST_ADDR)) u_part (
    .clk(clk), .rst_n(rst_n), .do_start(do_start), .do_stop(do_stop),
    .addr(ctl_addr), .daa_q(daa_active), .match(tgt_match), .evt_fail(tgt_evt_fail),
    .part_q(part_q), .new_part(new_part), .start_bcast(start_bcast),
    .start_ack(start_ack)
  );

  txr_ccc_state #(.DAA_CODE(DAA_CODE)) u_ccc (
    .clk(clk), .rst_n(rst_n), .do_start(do_start), .do_stop(do_stop),
    .do_wr(do_wr), .start_bcast(start_bcast), .wdata(ctl_wdata),
    .bcast_q(bcast_active), .ccc_q(ccc_active), .daa_q(daa_active),
    .wr_in_ccc(wr_in_ccc), .wr_code(wr_code)
  );

  txr_resp #(.N_TGT(N_TGT)) u_resp (
    .clk(clk), .rst_n(rst_n), .do_start(do_start), .do_wr(do_wr), .do_rd(do_rd),
    .start_ack(start_ack), .part_q(part_q), .wr_nack(tgt_wr_nack),
    .wr_in_ccc(wr_in_ccc), .wr_code(wr_code), .rdata(tgt_rdata),
    .rd_sel(rd_sel), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata)
  );

  assign bus_busy      = |part_q;
  assign tgt_addr      = ctl_addr;
  assign tgt_rnw       = ctl_rnw;
  assign tgt_wdata     = ctl_wdata;
  assign tgt_ccc_mode  = wr_in_ccc;
  assign tgt_ccc_code  = wr_code;
  assign tgt_start_evt = do_start ? new_part : '0;
  assign tgt_wr_en     = do_wr ? part_q : '0;
  assign tgt_rd_en     = do_rd ? rd_sel : '0;
  assign tgt_stop_evt  = do_stop ? (daa_active ? '1 : part_q) : '0;
  assign tgt_nack_evt  = do_nack ? part_q : '0;

  assert_nomatch_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_start && tgt_match == '0) |=> rsp_valid && !rsp_ack);
  assert_stop_idles_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop |=> !bus_busy && !rsp_valid);
  assert_nack_keeps_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    do_nack |=> $stable(bus_busy) && !rsp_valid);
  assert_bcast_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_start |=> bcast_active == $past(ctl_addr == BCAST_ADDR));

endmodule

// File: tb/txr_router_tb.sv
module txr_router_tb_top;
  localparam int N = 4;
  localparam logic [6:0] BC = 7'h7E;
  localparam logic [7:0] DAA = 8'h07;

  logic clk = 0, rst_n = 0;
  logic ctl_start = 0, ctl_rnw = 0, ctl_wr = 0, ctl_rd = 0, ctl_nack = 0, ctl_stop = 0;
  logic [6:0] ctl_addr = 0;
  logic [7:0] ctl_wdata = 0;
  logic rsp_valid, rsp_ack, bus_busy, bcast_active, ccc_active, daa_active;
  logic [7:0] rsp_rdata, tgt_wdata, tgt_ccc_code;
  logic [6:0] tgt_addr;
  logic tgt_rnw, tgt_ccc_mode;
  logic [N-1:0] tgt_start_evt, tgt_wr_en, tgt_rd_en, tgt_stop_evt, tgt_nack_evt;
  logic [N-1:0] tgt_match = 0, tgt_evt_fail = 0, tgt_wr_nack = 0;
  logic [8*N-1:0] tgt_rdata = 0;

  always #2 clk = ~clk;

  txr_router #(.N_TGT(N)) dut_i (.*);

  int errors = 0, checks = 0;
  // Reference model state
  logic [N-1:0] m_part;
  logic m_bc, m_ccc, m_daa;
  logic [7:0] m_code;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] first_of(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [7:0] byte_of(input logic [8*N-1:0] d, input logic [N-1:0] oh);
    for (int i = 0; i < N; i++) if (oh[i]) return d[i*8 +: 8];
    return 8'hFF;
  endfunction

  // kind: 0 start, 1 write, 2 read, 3 nack, 4 stop
  task automatic op(input int kind, input logic [6:0] a, input logic [7:0] wd,
                    input logic [N-1:0] mt, input logic [N-1:0] fl,
                    input logic [N-1:0] nk, input logic [8*N-1:0] rd);
    logic [N-1:0] em, sel;
    logic e_valid, e_ack, inc;
    logic [7:0] e_rd, cd;
    ctl_addr = a; ctl_wdata = wd; tgt_match = mt; tgt_evt_fail = fl;
    tgt_wr_nack = nk; tgt_rdata = rd; ctl_rnw = wd[0];
    ctl_start = (kind == 0); ctl_wr = (kind == 1); ctl_rd = (kind == 2);
    ctl_nack = (kind == 3); ctl_stop = (kind == 4);
    #1;
    e_valid = 0; e_ack = 0; e_rd = 8'hFF;
    sel = first_of(m_part);
    case (kind)
      0: begin
        em = (m_daa && a != BC) ? '0 : mt;
        check(tgt_start_evt == em, "R2 start events", 32'(tgt_start_evt), 32'(em));
        e_valid = 1;
        e_ack = (|em) && (a == BC || !(|(fl & em)));
        m_part = em; m_bc = (a == BC);
        if (a == BC && !m_daa) m_ccc = 0;
      end
      1: begin
        check(tgt_wr_en == m_part, "R8 write fanout", 32'(tgt_wr_en), 32'(m_part));
        inc = m_ccc || m_bc; cd = m_ccc ? m_code : wd;
        e_valid = 1;
        e_ack = !((|(nk & m_part)) && (!inc || cd[7]));
        if (m_bc && !m_ccc) begin
          m_code = wd; m_ccc = 1;
          if (wd == DAA) m_daa = 1;
        end
      end
      2: begin
        check(tgt_rd_en == sel, "R9 read strobe", 32'(tgt_rd_en), 32'(sel));
        e_valid = 1; e_ack = 1; e_rd = byte_of(rd, sel);
      end
      3: begin
        check(tgt_nack_evt == m_part, "R11 nack events", 32'(tgt_nack_evt), 32'(m_part));
      end
      default: begin
        em = m_daa ? '1 : m_part;
        check(tgt_stop_evt == em, "R10 stop events", 32'(tgt_stop_evt), 32'(em));
        m_part = '0; m_bc = 0; m_ccc = 0; m_daa = 0; m_code = 0;
      end
    endcase
    @(negedge clk);
    ctl_start = 0; ctl_wr = 0; ctl_rd = 0; ctl_nack = 0; ctl_stop = 0;
    check(rsp_valid == e_valid, "R2 rsp_valid", 32'(rsp_valid), 32'(e_valid));
    if (e_valid) begin
      if (kind == 0) check(rsp_ack == e_ack, "R3 R4 start ack", 32'(rsp_ack), 32'(e_ack));
      if (kind == 1) check(rsp_ack == e_ack, "R8 write ack", 32'(rsp_ack), 32'(e_ack));
      if (kind == 2) check(rsp_ack && rsp_rdata == e_rd, "R9 read data",
                           {23'd0, rsp_ack, rsp_rdata}, {23'd0, 1'b1, e_rd});
    end
    check(bus_busy == (|m_part), "R2 busy", 32'(bus_busy), 32'(|m_part));
    check({bcast_active, ccc_active, daa_active} == {m_bc, m_ccc, m_daa},
          "R5 R6 R7 flags", 32'({bcast_active, ccc_active, daa_active}),
          32'({m_bc, m_ccc, m_daa}));
  endtask

  bit done = 0;
  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [8*N-1:0] rdv;
    int unsigned seed;
    m_part = 0; m_bc = 0; m_ccc = 0; m_daa = 0; m_code = 0;
    seed = $urandom(32'h1C3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!bus_busy && !bcast_active && !ccc_active && !daa_active && !rsp_valid,
          "R1 reset state", {bus_busy, bcast_active, ccc_active, daa_active, rsp_valid}, 0);
    rdv = 32'hA4B3C2D1;
    // R3 nobody matches
    op(0, 7'h30, 0, 4'b0000, 0, 0, rdv);
    // R9 read on empty bus -> FF
    op(2, 0, 0, 0, 0, 0, rdv);
    // R4 direct start, fail on participant -> NACK
    op(0, 7'h30, 0, 4'b0110, 4'b0100, 0, rdv);
    // R9 lowest index participant
    op(2, 0, 0, 0, 0, 0, rdv);
    // R8 plain write nack
    op(1, 0, 8'h55, 0, 0, 4'b0010, rdv);
    op(3, 0, 0, 0, 0, 0, rdv);               // R11
    op(4, 0, 0, 0, 0, 0, rdv);               // R10
    // R4 broadcast ignores fail; R6 ENTDAA capture; R8 nack hidden
    op(0, BC, 0, 4'b1111, 4'b1111, 0, rdv);
    op(1, 0, DAA, 0, 0, 4'b1111, rdv);
    // R7 ENTDAA persists; direct address matches nobody
    op(0, 7'h22, 0, 4'b1111, 0, 0, rdv);
    op(0, BC, 0, 4'b1000, 0, 0, rdv);
    op(4, 0, 0, 0, 0, 0, rdv);               // R10 stop to all in ENTDAA
    // R8 direct CCC: broadcast, code 0x8A, repeated START to target, nack passes
    op(0, BC, 0, 4'b0011, 0, 0, rdv);
    op(1, 0, 8'h8A, 0, 0, 0, rdv);
    op(0, 7'h11, 0, 4'b0001, 0, 0, rdv);     // R5 ccc kept on direct START
    op(1, 0, 8'h3C, 0, 0, 4'b0001, rdv);
    op(0, BC, 0, 4'b0011, 0, 0, rdv);        // R5 new broadcast clears CCC
    op(4, 0, 0, 0, 0, 0, rdv);
    // Constrained random
    for (int n = 0; n < 2000; n++) begin
      int k; logic [6:0] a; logic [7:0] wd; int r;
      r = $urandom_range(0, 99);
      k = (r < 30) ? 0 : (r < 60) ? 1 : (r < 80) ? 2 : (r < 90) ? 3 : 4;
      a = ($urandom_range(0, 9) < 4) ? BC : 7'($urandom);
      r = $urandom_range(0, 9);
      wd = (r < 2) ? DAA : (r < 5) ? (8'h80 | 8'($urandom)) : 8'($urandom);
      op(k, a, wd, N'($urandom), N'($urandom), N'($urandom), {$urandom});
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule